// File: doc/BRIEF.md
# Multi-Hart Machine Timer Compare Unit

This peripheral gives every hart of a multi-hart processor a timer interrupt. One 64-bit time counter is shared by all harts, and each hart owns a 64-bit compare register. A hart's interrupt line stays high for as long as the shared count has reached or passed that hart's compare value. Software sets the line up again by writing a larger compare value or a smaller count.

All registers live in one 32 KiB byte-offset window. They are reached over a plain 32-bit register bus that has read and write strobes. Each 64-bit register appears as two 32-bit words, and a write to one word leaves the other word untouched. Any access at or above the end of the window returns an access fault. The counter advances on a tick-enable input, so the time base can run slower than the bus clock.

Top module: `mtime_cmp_unit`

## Requirements
- R1: After synchronous reset the counter is zero, every compare register holds all ones, every interrupt line is low, and the read-valid and both fault outputs are low.
- R2: The counter adds one on every clock edge at which the tick enable is high and no counter write is taking place. Otherwise it holds its value.
- R3: The counter sits at offset 0x7FF8 (bits 31:0) and 0x7FFC (bits 63:32). A write to one half replaces only that half, and counting then continues from the loaded value, with carry from the low half into the high half. A write edge suppresses that edge's increment.
- R4: The compare register of hart h sits at offset 8*h (bits 31:0) and 8*h+4 (bits 63:32). Offset bit 2 selects the half, and a write to one half keeps the other half.
- R5: Interrupt line h is high exactly when the counter is greater than or equal to compare register h, comparing the values the registers held during the previous cycle. The line changes one clock edge after the register change.
- R6: A read strobe returns read-valid, read data and a low read fault at the next clock edge. The data is the addressed half as it stood when the strobe was sampled.
- R7: Any access at offset 0x8000 or above faults. A read returns read-valid with the read fault high and zero data. A write raises the write-fault output for one cycle after the strobe and changes no register.
- R8: Compare slots whose index is N_HARTS or more, below offset 0x7FF8, read as zero and ignore writes, and raise no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Counter advance enable |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W | Byte offset into the window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid with rvalid |
| rvalid | output | 1 | Read response valid |
| rd_fault | output | 1 | Load access fault with rvalid |
| wr_fault | output | 1 | Store access fault, one cycle after the strobe |
| timer_irq | output | N_HARTS | Level timer interrupt per hart |

## Verification
A read response and a write fault are due at the first clock edge after the strobe. A register write takes effect at that same edge, and an interrupt line follows one edge later. The bench drives every strobe for exactly one cycle on the falling edge and samples responses on the next falling edge. It samples interrupt lines two falling edges after a change, and it checks the one-edge lag directly by also sampling the line one edge early. Tick enable is held low during readbacks, so each counter value the bench expects is exact.

// File: rtl/mtc_pkg.sv
package mtc_pkg;
  localparam int TW      = 64;
  localparam int BW      = 32;
  localparam int IDX_W   = 12;
  localparam int WIN_END = 32'h8000;
  localparam logic [IDX_W-1:0] TIME_IDX = 12'hFFF;

  typedef enum logic [1:0] {
    SEL_CMP  = 2'd0,
    SEL_TIME = 2'd1,
    SEL_BAD  = 2'd2
  } sel_e;
endpackage

// File: rtl/mtc_decode.sv
module mtc_decode
  import mtc_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  output sel_e              sel,
  output logic              hi,
  output logic [IDX_W-1:0]  idx
);
  logic [31:0] ofs;

  always_comb begin
    ofs = 32'(addr);
    idx = ofs[IDX_W+2:3];
    hi  = ofs[2];
    if (ofs >= WIN_END)       sel = SEL_BAD;
    else if (idx == TIME_IDX) sel = SEL_TIME;
    else                      sel = SEL_CMP;
  end
endmodule

// File: rtl/mtc_counter.sv
module mtc_counter
  import mtc_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_en,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [BW-1:0] wdata,
  output logic [TW-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst)          count <= '0;
    else if (wr_lo)   count[BW-1:0]  <= wdata;
    else if (wr_hi)   count[TW-1:BW] <= wdata;
    else if (tick_en) count <= count + TW'(1);
  end
endmodule

// File: rtl/mtc_cmp_bank.sv
module mtc_cmp_bank
  import mtc_pkg::*;
#(
  parameter int N_HARTS = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_lo,
  input  logic                         wr_hi,
  input  logic [IDX_W-1:0]             idx,
  input  logic [BW-1:0]                wdata,
  input  logic [TW-1:0]                count,
  output logic [N_HARTS-1:0][TW-1:0]   cmp_q,
  output logic [N_HARTS-1:0]           irq
);
  for (genvar h = 0; h < N_HARTS; h++) begin : g_hart
    logic hit;
    assign hit = (idx == IDX_W'(h));

    always_ff @(posedge clk) begin
      if (rst) begin
        cmp_q[h] <= '1;
        irq[h]   <= 1'b0;
      end else begin
        if (hit && wr_lo) cmp_q[h][BW-1:0]  <= wdata;
        if (hit && wr_hi) cmp_q[h][TW-1:BW] <= wdata;
        irq[h] <= (count >= cmp_q[h]);
      end
    end
  end
endmodule

// File: rtl/mtime_cmp_unit.sv
module mtime_cmp_unit
  import mtc_pkg::*;
#(
  parameter int N_HARTS = 4,
  parameter int ADDR_W  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick_en,
  input  logic               rd_en,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [31:0]        wdata,
  output logic [31:0]        rdata,
  output logic               rvalid,
  output logic               rd_fault,
  output logic               wr_fault,
  output logic [N_HARTS-1:0] timer_irq
);
  sel_e                       sel;
  logic                       hi;
  logic [IDX_W-1:0]           idx;
  logic [TW-1:0]              count_q;
  logic [N_HARTS-1:0][TW-1:0] cmp_q;
  logic                       t_wr_lo, t_wr_hi, c_wr_lo, c_wr_hi;
  logic [BW-1:0]              rd_mux;

  mtc_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (addr),
    .sel  (sel),
    .hi   (hi),
    .idx  (idx)
  );

  assign t_wr_lo = wr_en && (sel == SEL_TIME) && !hi;
  assign t_wr_hi = wr_en && (sel == SEL_TIME) &&  hi;
  assign c_wr_lo = wr_en && (sel == SEL_CMP)  && !hi;
  assign c_wr_hi = wr_en && (sel == SEL_CMP)  &&  hi;

  mtc_counter u_cnt (
    .clk     (clk),
    .rst     (rst),
    .tick_en (tick_en),
    .wr_lo   (t_wr_lo),
    .wr_hi   (t_wr_hi),
    .wdata   (wdata),
    .count   (count_q)
  );

  mtc_cmp_bank #(.N_HARTS(N_HARTS)) u_bank (
    .clk   (clk),
    .rst   (rst),
    .wr_lo (c_wr_lo),
    .wr_hi (c_wr_hi),
    .idx   (idx),
    .wdata (wdata),
    .count (count_q),
    .cmp_q (cmp_q),
    .irq   (timer_irq)
  );

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_TIME: rd_mux = hi ? count_q[TW-1:BW] : count_q[BW-1:0];
      SEL_CMP: begin
        for (int h = 0; h < N_HARTS; h++) begin
          if (idx == IDX_W'(h)) rd_mux = hi ? cmp_q[h][TW-1:BW] : cmp_q[h][BW-1:0];
        end
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      rvalid   <= 1'b0;
      rd_fault <= 1'b0;
      wr_fault <= 1'b0;
    end else begin
      rvalid   <= rd_en;
      rd_fault <= rd_en && (sel == SEL_BAD);
      wr_fault <= wr_en && (sel == SEL_BAD);
      if (rd_en) rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/mtc_checker.sv
module mtc_checker #(
  parameter int N_HARTS = 4,
  parameter int ADDR_W  = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               tick_en,
  input logic               rd_en,
  input logic               wr_en,
  input logic [ADDR_W-1:0]  addr,
  input logic               rvalid,
  input logic               rd_fault,
  input logic               wr_fault,
  input logic [N_HARTS-1:0] timer_irq,
  input logic [63:0]        count_q
);
  logic bad;
  assign bad = 32'(addr) >= 32'h8000;

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (count_q == 64'd0) && (timer_irq == '0) && !rvalid && !wr_fault);

  p_tick_r2: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && tick_en) |=> count_q == $past(count_q) + 64'd1);

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !tick_en) |=> $stable(count_q));

  p_rd_resp_r6: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rvalid);

  p_no_stray_valid_r6: assert property (@(posedge clk) disable iff (rst)
    rvalid |-> $past(rd_en));

  p_good_read_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !bad) |=> !rd_fault);

  p_bad_read_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && bad) |=> rd_fault);

  p_bad_write_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && bad) |=> wr_fault);

  p_bad_write_keep_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && bad && !tick_en) |=> $stable(count_q));

  p_wfault_cause_r7: assert property (@(posedge clk) disable iff (rst)
    wr_fault |-> $past(wr_en));

  for (genvar h = 0; h < N_HARTS; h++) begin : g_irq
    p_irq_fall_r5: assert property (@(posedge clk) disable iff (rst)
      $fell(timer_irq[h]) |-> $past(wr_en, 2));
  end
endmodule

bind mtime_cmp_unit mtc_checker #(.N_HARTS(N_HARTS), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .tick_en   (tick_en),
  .rd_en     (rd_en),
  .wr_en     (wr_en),
  .addr      (addr),
  .rvalid    (rvalid),
  .rd_fault  (rd_fault),
  .wr_fault  (wr_fault),
  .timer_irq (timer_irq),
  .count_q   (count_q)
);

// File: tb/test_mtime_cmp_unit.sv
module test_mtime_cmp_unit;
  localparam int N_HARTS = 4;
  localparam int ADDR_W  = 16;
  localparam logic [15:0] T_LO = 16'h7FF8;
  localparam logic [15:0] T_HI = 16'h7FFC;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               tick_en = 1'b0;
  logic               rd_en = 1'b0;
  logic               wr_en = 1'b0;
  logic [ADDR_W-1:0]  addr = '0;
  logic [31:0]        wdata = '0;
  logic [31:0]        rdata;
  logic               rvalid, rd_fault, wr_fault;
  logic [N_HARTS-1:0] timer_irq;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  logic [31:0] r_d;
  logic        r_v, r_f, w_f;

  always #2 clk = ~clk;

  mtime_cmp_unit #(.N_HARTS(N_HARTS), .ADDR_W(ADDR_W)) i_mtime_cmp_unit (
    .clk(clk), .rst(rst), .tick_en(tick_en), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid),
    .rd_fault(rd_fault), .wr_fault(wr_fault), .timer_irq(timer_irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_write(input logic [15:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    w_f = wr_fault;
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [15:0] a);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    r_d = rdata; r_v = rvalid; r_f = rd_fault;
    rd_en = 1'b0;
  endtask

  task automatic tick(input int n);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  task automatic t_reset;
    chk("R1 irq", 64'(timer_irq), 64'd0);
    chk("R1 rvalid", 64'(rvalid), 64'd0);
    chk("R1 wr_fault", 64'(wr_fault), 64'd0);
    do_read(T_LO);
    chk("R1 count lo", 64'(r_d), 64'd0);
    chk("R6 valid", 64'(r_v), 64'd1);
    chk("R6 no fault", 64'(r_f), 64'd0);
    do_read(16'h0004);
    chk("R1 cmp0 hi", 64'(r_d), 64'hFFFF_FFFF);
    do_read(16'h0018);
    chk("R1 cmp3 lo", 64'(r_d), 64'hFFFF_FFFF);
    idle(1);
    chk("R6 valid drops", 64'(rvalid), 64'd0);
  endtask

  task automatic t_tick;
    do_write(T_LO, 32'd100);
    chk("R7 no wfault on good write", 64'(w_f), 64'd0);
    tick(10);
    do_read(T_LO);
    chk("R2 ten ticks", 64'(r_d), 64'd110);
    idle(5);
    do_read(T_LO);
    chk("R2 hold without tick", 64'(r_d), 64'd110);
  endtask

  task automatic t_halves;
    do_write(T_HI, 32'h1);
    do_read(T_LO);
    chk("R3 lo kept on hi write", 64'(r_d), 64'd110);
    do_write(T_LO, 32'hFFFF_FFFF);
    do_read(T_HI);
    chk("R3 hi kept on lo write", 64'(r_d), 64'h1);
    tick(1);
    do_read(T_LO);
    chk("R3 carry lo", 64'(r_d), 64'd0);
    do_read(T_HI);
    chk("R3 carry hi", 64'(r_d), 64'd2);
  endtask

  task automatic t_prio;
    tick_en = 1'b1;
    do_write(T_LO, 32'd500);
    tick_en = 1'b0;
    do_read(T_LO);
    chk("R3 write beats tick", 64'(r_d), 64'd500);
    tick_en = 1'b1;
    do_write(T_HI, 32'd7);
    tick_en = 1'b0;
    do_read(T_LO);
    chk("R3 hi write suppresses tick", 64'(r_d), 64'd500);
    do_read(T_HI);
    chk("R3 hi loaded", 64'(r_d), 64'd7);
  endtask

  task automatic t_irq;
    do_write(16'h000C, 32'd0);
    do_write(16'h0008, 32'd50);
    do_write(T_HI, 32'd0);
    do_write(T_LO, 32'd40);
    idle(2);
    chk("R5 below compare", 64'(timer_irq), 64'b0000);
    tick(10);
    idle(2);
    chk("R5 equal raises", 64'(timer_irq), 64'b0010);
    do_write(T_LO, 32'd49);
    idle(2);
    chk("R5 one below", 64'(timer_irq), 64'b0000);
    tick(1);
    chk("R5 one edge lag", 64'(timer_irq), 64'b0000);
    idle(1);
    chk("R5 rises after lag", 64'(timer_irq), 64'b0010);
    do_write(16'h0008, 32'd100);
    idle(2);
    chk("R5 raised compare clears", 64'(timer_irq), 64'b0000);
    do_write(16'h001C, 32'd0);
    idle(2);
    chk("R4 cmp3 lo kept", 64'(timer_irq), 64'b0000);
    do_write(16'h0018, 32'd10);
    idle(2);
    chk("R5 hart3 raised", 64'(timer_irq), 64'b1000);
  endtask

  task automatic t_cmp_halves;
    do_read(16'h0008);
    chk("R4 cmp1 lo", 64'(r_d), 64'd100);
    do_read(16'h000C);
    chk("R4 cmp1 hi", 64'(r_d), 64'd0);
    do_write(16'h0014, 32'h1234_5678);
    do_read(16'h0010);
    chk("R4 cmp2 lo kept", 64'(r_d), 64'hFFFF_FFFF);
    do_read(16'h0014);
    chk("R4 cmp2 hi", 64'(r_d), 64'h1234_5678);
  endtask

  task automatic t_unused;
    do_write(16'h0020, 32'd5);
    chk("R8 no wfault", 64'(w_f), 64'd0);
    do_read(16'h0020);
    chk("R8 reads zero", 64'(r_d), 64'd0);
    chk("R8 no rfault", 64'(r_f), 64'd0);
    do_read(16'h7FF4);
    chk("R8 last slot zero", 64'(r_d), 64'd0);
    chk("R8 last slot valid", 64'(r_v), 64'd1);
  endtask

  task automatic t_fault;
    do_read(16'h8000);
    chk("R7 rfault", 64'(r_f), 64'd1);
    chk("R7 rvalid", 64'(r_v), 64'd1);
    chk("R7 rdata zero", 64'(r_d), 64'd0);
    do_read(16'hFFFC);
    chk("R7 rfault top", 64'(r_f), 64'd1);
    do_write(16'h8000, 32'd0);
    chk("R7 wfault", 64'(w_f), 64'd1);
    idle(1);
    chk("R7 wfault one cycle", 64'(wr_fault), 64'd0);
    do_read(16'h0000);
    chk("R7 cmp0 untouched", 64'(r_d), 64'hFFFF_FFFF);
    do_write(16'hFFF8, 32'd3);
    do_read(T_LO);
    chk("R7 counter untouched", 64'(r_d), 64'd50);
  endtask

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    t_reset();
    t_tick();
    t_halves();
    t_prio();
    t_irq();
    t_cmp_halves();
    t_unused();
    t_fault();
    finish_run();
  end
endmodule